// File: doc/BRIEF.md
# Triple-Redundant Shared Section with Processor Switchover

The block is the shared section that sits between two redundant processors. It holds a 64-bit transfer register and a 16-bit down-counting timer, and it decides which of the two processors owns the shared section. Each of these three state elements is kept in three independent copies. A bitwise two-of-three majority vote over the copies forms every output. On every clock, each copy is rewritten from the voted value, so an upset in one copy is repaired before a second upset can join it.

Only the active processor may write the transfer register. Only the I/O section of the active side is enabled. A switchover command moves ownership to the other side, and this can happen any number of times. When automatic switchover is enabled, the timer running down to zero moves ownership as well. A fault port can XOR a mask into one chosen copy of each state element, so the bench can upset the copies directly.

Top module: `tmr_common_sect`

## Requirements
- R1: While rst_ni is low, and after it is released, the outputs are: xreg_o = 0, tmr_o = 16'hFFFF, expired_o = 0, active_side_o = 0 (primary) and io_en_o = 2'b01.
- R2: A write with wr_en_i = 1 and wr_side_i equal to active_side_o is accepted. Its data appears on xreg_o after the next rising clock edge.
- R3: A write whose wr_side_i differs from active_side_o is ignored, and xreg_o keeps its value.
- R4: io_en_o has exactly one bit set. Bit 0 is set when the primary is active (side 0), and bit 1 is set when the secondary is active (side 1).
- R5: Each cycle with swo_cmd_i = 1 toggles active_side_o at the next edge. A write issued in that same cycle is judged against the side that was active before the toggle.
- R6: tmr_load_i = 1 loads tmr_load_val_i into the timer at the next edge. A load takes priority over counting.
- R7: With tmr_en_i = 1 and no load, a nonzero timer count decrements by one per cycle. A zero count stays at zero. With tmr_en_i = 0, the count holds.
- R8: expired_o is 1 exactly when the voted timer count is zero.
- R9: When auto_swo_en_i = 1, a cycle in which an enabled timer steps from 1 to 0 toggles the active side. If a switchover command falls in the same cycle, the side toggles only once. A count that stays at zero causes no further toggles.
- R10: flt_rep_i selects a copy: 0, 1 or 2 picks that copy, and 3 picks none. At the next edge, the selected copy takes its normal next value XOR flt_xreg_i, flt_tmr_i and flt_side_i for the three elements. A fault in any single copy leaves every output unchanged.
- R11: A copy corrupted by R10 is restored to the voted value on the following edge. As a result, faults on different copies in consecutive cycles never disturb the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Transfer register write strobe |
| wr_side_i | input | 1 | Side issuing the write (0 primary, 1 secondary) |
| wr_data_i | input | 64 | Write data |
| tmr_load_i | input | 1 | Timer reload strobe |
| tmr_load_val_i | input | 16 | Timer reload value |
| tmr_en_i | input | 1 | Timer count enable |
| auto_swo_en_i | input | 1 | Allow timer expiry to trigger switchover |
| swo_cmd_i | input | 1 | Switchover command |
| flt_rep_i | input | 2 | Copy selected for fault injection (3 = none) |
| flt_xreg_i | input | 64 | XOR mask for the selected transfer register copy |
| flt_tmr_i | input | 16 | XOR mask for the selected timer copy |
| flt_side_i | input | 1 | XOR mask for the selected side copy |
| xreg_o | output | 64 | Voted transfer register |
| tmr_o | output | 16 | Voted timer count |
| expired_o | output | 1 | Voted timer count is zero |
| active_side_o | output | 1 | Voted active side |
| io_en_o | output | 2 | I/O section enables, one per side |

## Verification
Two pairs of events are driven into the same cycle. The first is a switchover command together with a write from the currently active side. The bench expects the write to land and the side to flip at that one edge. A write from the new side in the following cycle must also land, while a write from the old side must be dropped. The second pair is a switchover command in the exact cycle the timer steps from 1 to 0 with automatic switchover enabled. The expected side is computed as one toggle, not two. Faults are injected on top of ongoing writes and countdowns, and the reference outputs ignore the fault ports entirely.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NREP = 3;
  localparam logic [1:0] FLT_NONE = 2'd3;
endpackage

// File: rtl/tmr_vote.sv
module tmr_vote #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] q_o
);
  assign q_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/tmr_rep_reg.sv
module tmr_rep_reg
  import tmr_pkg::*;
#(
  parameter int          W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] nxt_i,
  input  logic [1:0]   flt_rep_i,
  input  logic [W-1:0] flt_mask_i,
  output logic [W-1:0] q_o
);
  logic [NREP-1:0][W-1:0] rep_q;

  // every copy reloads from the voted next value: scrubbing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREP; r++) rep_q[r] <= RST;
    end else begin
      for (int r = 0; r < NREP; r++)
        rep_q[r] <= nxt_i ^ ((flt_rep_i == 2'(r)) ? flt_mask_i : '0);
    end
  end

  tmr_vote #(.W(W)) u_vote (
    .a_i(rep_q[0]),
    .b_i(rep_q[1]),
    .c_i(rep_q[2]),
    .q_o(q_o)
  );

  // R11
  voted_tracks_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> q_o == $past(nxt_i));
endmodule

// File: rtl/tmr_timer_ctl.sv
module tmr_timer_ctl #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         en_i,
  input  logic         auto_en_i,
  output logic [W-1:0] nxt_o,
  output logic         zero_o,
  output logic         auto_evt_o
);
  logic cnt_zero, cnt_one;

  assign cnt_zero = (cnt_i == '0);
  assign cnt_one  = (cnt_i == W'(1));

  always_comb begin
    if (load_i)                nxt_o = load_val_i;
    else if (en_i && !cnt_zero) nxt_o = cnt_i - W'(1);
    else                       nxt_o = cnt_i;
  end

  assign zero_o     = cnt_zero;
  assign auto_evt_o = auto_en_i && en_i && !load_i && cnt_one;

  // R6
  tmr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_i == $past(load_val_i));
  // R7
  tmr_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && cnt_i != '0) |=> cnt_i == W'($past(cnt_i) - W'(1)));
  // R7
  tmr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (!en_i || cnt_i == '0)) |=> $stable(cnt_i));
endmodule

// File: rtl/tmr_common_sect.sv
module tmr_common_sect
  import tmr_pkg::*;
#(
  parameter int XREG_W = 64,
  parameter int TMR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_side_i,
  input  logic [XREG_W-1:0] wr_data_i,
  input  logic              tmr_load_i,
  input  logic [TMR_W-1:0]  tmr_load_val_i,
  input  logic              tmr_en_i,
  input  logic              auto_swo_en_i,
  input  logic              swo_cmd_i,
  input  logic [1:0]        flt_rep_i,
  input  logic [XREG_W-1:0] flt_xreg_i,
  input  logic [TMR_W-1:0]  flt_tmr_i,
  input  logic              flt_side_i,
  output logic [XREG_W-1:0] xreg_o,
  output logic [TMR_W-1:0]  tmr_o,
  output logic              expired_o,
  output logic              active_side_o,
  output logic [1:0]        io_en_o
);
  localparam logic [TMR_W-1:0] TMR_RST = '1;

  logic              side_q, side_nxt;
  logic [XREG_W-1:0] xreg_q, xreg_nxt;
  logic [TMR_W-1:0]  tmr_q, tmr_nxt;
  logic              wr_acc, auto_evt;

  assign wr_acc   = wr_en_i && (wr_side_i == side_q);
  assign xreg_nxt = wr_acc ? wr_data_i : xreg_q;
  assign side_nxt = side_q ^ (swo_cmd_i | auto_evt);

  tmr_rep_reg #(.W(XREG_W), .RST('0)) u_xreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .nxt_i(xreg_nxt),
    .flt_rep_i(flt_rep_i), .flt_mask_i(flt_xreg_i), .q_o(xreg_q)
  );

  tmr_timer_ctl #(.W(TMR_W)) u_tctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(tmr_q),
    .load_i(tmr_load_i), .load_val_i(tmr_load_val_i),
    .en_i(tmr_en_i), .auto_en_i(auto_swo_en_i),
    .nxt_o(tmr_nxt), .zero_o(expired_o), .auto_evt_o(auto_evt)
  );

  tmr_rep_reg #(.W(TMR_W), .RST(TMR_RST)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .nxt_i(tmr_nxt),
    .flt_rep_i(flt_rep_i), .flt_mask_i(flt_tmr_i), .q_o(tmr_q)
  );

  tmr_rep_reg #(.W(1), .RST(1'b0)) u_side (
    .clk_i(clk_i), .rst_ni(rst_ni), .nxt_i(side_nxt),
    .flt_rep_i(flt_rep_i), .flt_mask_i(flt_side_i), .q_o(side_q)
  );

  assign xreg_o        = xreg_q;
  assign tmr_o         = tmr_q;
  assign active_side_o = side_q;
  assign io_en_o       = side_q ? 2'b10 : 2'b01;

  // R3
  inactive_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_side_i == active_side_o) |=> $stable(xreg_o));
  // R2
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_side_i == active_side_o) |=> xreg_o == $past(wr_data_i));
  // R5
  swo_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swo_cmd_i |=> active_side_o != $past(active_side_o));
  // R9
  no_spurious_swo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(swo_cmd_i || (auto_swo_en_i && tmr_en_i && !tmr_load_i && tmr_o == TMR_W'(1)))
      |=> $stable(active_side_o));
  // R4
  io_en_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(io_en_o) && io_en_o != 2'b00);
endmodule

// File: tb/tmr_common_sect_tb_top.sv
module tmr_common_sect_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, wr_side = 1'b0;
  logic [63:0] wr_data = '0;
  logic        tload = 1'b0;
  logic [15:0] tval = '0;
  logic        ten = 1'b0, auto_en = 1'b0, swo = 1'b0;
  logic [1:0]  frep = 2'd3;
  logic [63:0] fx = '0;
  logic [15:0] ft = '0;
  logic        fs = 1'b0;
  logic [63:0] xreg;
  logic [15:0] tmr;
  logic        expired, side;
  logic [1:0]  io_en;

  logic [63:0] m_xreg = '0;
  logic [15:0] m_tmr  = 16'hFFFF;
  logic        m_side = 1'b0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  tmr_common_sect dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_side_i(wr_side),
    .wr_data_i(wr_data), .tmr_load_i(tload), .tmr_load_val_i(tval),
    .tmr_en_i(ten), .auto_swo_en_i(auto_en), .swo_cmd_i(swo),
    .flt_rep_i(frep), .flt_xreg_i(fx), .flt_tmr_i(ft), .flt_side_i(fs),
    .xreg_o(xreg), .tmr_o(tmr), .expired_o(expired),
    .active_side_o(side), .io_en_o(io_en)
  );

  task automatic chk(string tag);
    logic [83:0] act, exp;
    act = {xreg, tmr, expired, side, io_en};
    exp = {m_xreg, m_tmr, (m_tmr == 16'd0), m_side, (m_side ? 2'b10 : 2'b01)};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference update from requirements, then one clock, then compare
  task automatic tick(string tag);
    logic acc, evt;
    acc = wr_en && (wr_side == m_side);
    evt = auto_en && ten && !tload && (m_tmr == 16'd1);
    if (acc) m_xreg = wr_data;
    if (tload) m_tmr = tval;
    else if (ten && m_tmr != 16'd0) m_tmr = m_tmr - 16'd1;
    if (swo || evt) m_side = ~m_side;
    @(negedge clk);
    chk(tag);
    wr_en = 1'b0; tload = 1'b0; swo = 1'b0;
    frep = 2'd3; fx = '0; ft = '0; fs = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release");

    // R2 writes from primary
    for (int i = 0; i < 8; i++) begin
      wr_en = 1'b1; wr_side = 1'b0;
      wr_data = 64'h0123_4567_89AB_CDEF * 64'(i + 1) ^ {32'(i), 32'hA5A5_0000};
      tick("R2 write primary");
    end
    // R3 write from inactive side
    wr_en = 1'b1; wr_side = 1'b1; wr_data = 64'hDEAD_BEEF_0000_1111;
    tick("R3 inactive write");
    tick("R3 hold after ignored write");

    // R5 switchover and R4 enables
    swo = 1'b1; tick("R5 R4 switch to secondary");
    wr_en = 1'b1; wr_side = 1'b1; wr_data = 64'h1111_2222_3333_4444;
    tick("R2 write secondary");
    wr_en = 1'b1; wr_side = 1'b0; wr_data = 64'h5555_6666_7777_8888;
    tick("R3 old primary ignored");
    // switchover and write in same cycle
    swo = 1'b1; wr_en = 1'b1; wr_side = 1'b1; wr_data = 64'h9999_AAAA_BBBB_CCCC;
    tick("R5 switch with write");
    wr_en = 1'b1; wr_side = 1'b1; wr_data = 64'h0F0F_0F0F_0F0F_0F0F;
    tick("R5 old side dropped");
    for (int i = 0; i < 4; i++) begin
      swo = 1'b1; tick("R5 repeated switchover");
    end

    // R6 R7 R8 timer
    tload = 1'b1; tval = 16'd5; tick("R6 load");
    ten = 1'b1;
    for (int i = 0; i < 8; i++) tick("R7 R8 countdown");
    tload = 1'b1; tval = 16'd300; tick("R6 load over count");
    tick("R7 dec");
    ten = 1'b0;
    tick("R7 hold disabled"); tick("R7 hold disabled");
    tload = 1'b1; tval = 16'd0; tick("R8 load zero");
    ten = 1'b1; tick("R7 stays zero");

    // R9 automatic switchover
    auto_en = 1'b1;
    tload = 1'b1; tval = 16'd3; tick("R9 load");
    for (int i = 0; i < 5; i++) tick("R9 auto countdown");
    tload = 1'b1; tval = 16'd2; tick("R9 reload");
    tick("R9 to one");
    swo = 1'b1; tick("R9 command with expiry");
    tick("R9 no retoggle at zero");
    auto_en = 1'b0;
    tload = 1'b1; tval = 16'd1; tick("R9 reload disabled");
    tick("R9 no auto when disabled");

    // R10 single copy faults under activity
    tload = 1'b1; tval = 16'd40000; tick("R6 load big");
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 16; k++) begin
        frep = 2'(r);
        fx = 64'hFFFF_FFFF_FFFF_FFFF >> k;
        ft = 16'(16'h8001 << (k % 16)) | 16'(k);
        fs = k[0];
        if (k % 3 == 0) begin
          wr_en = 1'b1; wr_side = m_side; wr_data = {16'(r), 16'(k), 32'h1357_9BDF};
        end
        if (k == 7) swo = 1'b1;
        tick("R10 single copy fault");
      end
    end

    // R11 faults hop across copies on consecutive cycles
    for (int k = 0; k < 30; k++) begin
      frep = 2'(k % 3);
      fx = '1; ft = '1; fs = 1'b1;
      if (k % 5 == 0) begin
        wr_en = 1'b1; wr_side = m_side; wr_data = 64'(k) * 64'h0101_0101_0101_0101;
      end
      tick("R11 scrub between faults");
    end
    ten = 1'b0;
    tick("R11 settle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule